// File: doc/BRIEF.md
# Windowed Watchdog Monitor with Key Refresh

This block watches over software running on a small controller. Software configures it through a byte-wide register port. A counter advances on a slow reference signal, which is divided down by a programmable prescaler. To refresh the counter, software writes two fixed key bytes to a service location, one after the other and close together in time. The refresh counts only while the counter sits between a lower and an upper compare value. If the counter passes the upper bound, an alarm output is raised. The alarm is also raised by a wrong key byte, by a second key that comes too late, by a refresh attempt below the lower bound, or by an external fault input that has been enabled and is at its active level. An optional interrupt follows the alarm.

Runaway code must not be able to weaken the protection. For that reason the compare values, the prescaler and the lower three control bits each take one write after reset. Any further write to them is refused with a bus error, and the stored value stays as it was. Because of this, a monitor that has been enabled cannot be switched off again, and one whose first control write leaves it disabled stays disabled until reset.

Top module: `keyed_window_watchdog`

## Requirements
- R1: After reset, control (offset 0) reads 0x00, lower compare (offset 2) reads 0x00, upper compare (offset 3) reads 0xFF, prescaler (offset 5) reads 0x00, and alarm and interrupt are low.
- R2: Offsets 2, 3 and 5 each accept one write after reset. A later write to any of them returns `bus_err` high in the cycle after the access and leaves the value unchanged. A later control write whose bits 2:0 differ from the stored ones also returns the error and leaves those bits unchanged. Writes to offset 4 never return an error.
- R3: Control bit 0 is enable. The first control write decides it: if set, the counter starts from zero with the alarm low. If that first write leaves enable clear, the block never counts and never raises the alarm until reset. An enabled block cannot be disabled.
- R4: While enabled, the counter advances once per (1 + prescaler) rising edges of `slow_clk_in` and saturates at its all-ones value.
- R5: The alarm rises once the counter is strictly greater than the upper compare. An upper compare of all-ones therefore never expires.
- R6: A write of 0xB4 to the service offset (1), followed within KEY_WIN bus cycles by a write of 0x2C, while the counter lies between the lower and upper compare inclusive, clears the counter and the prescaler phase and drops the alarm.
- R7: A service write that is not the expected next key byte raises the alarm and abandons the sequence.
- R8: If the second key byte has not arrived by KEY_WIN cycles after the first, the alarm is raised.
- R9: A correct key pair that completes while the counter is below the lower compare raises the alarm.
- R10: Control bit 2 enables the external input `mon_in`. Control bit 1 selects its active level: clear means active low, set means active high. An active input raises the alarm. With bit 2 clear, the input has no effect.
- R11: Control bit 3 enables the interrupt. `irq_out` is high while that bit is set and the alarm is up. Writing the bit back to zero removes the request and leaves the alarm as it is.
- R12: The service offset and the reserved offsets always read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_vld | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read access |
| bus_err | output | 1 | Transfer error, the cycle after a refused write |
| slow_clk_in | input | 1 | Slow reference clock, sampled and synchronised |
| mon_in | input | 1 | External fault input, synchronised |
| alarm_out | output | 1 | Registered alarm output |
| irq_out | output | 1 | Registered interrupt request |

## Verification
Every cycle, the assertions check the following. Locked registers hold their values and answer with an error. The counter only steps by one or returns to zero. Exceeding the upper compare raises the alarm on the next edge. A clean refresh drops it. The interrupt never appears without the alarm. An enabled monitor never turns itself off. The key-sequence timing needs the bench's scenarios: the last cycle that still counts as in time and the first that is late, a refresh below the window, a wrong first or second byte, and a refresh after expiry that has no effect. Those scenarios also cover prescaled expiry times across a sweep of divider and compare values, and the polarity and gating of the external input.

// File: rtl/kww_pkg.sv
package kww_pkg;
  localparam int BYTE_W = 8;
  localparam logic [2:0] OFS_CTRL = 3'd0;
  localparam logic [2:0] OFS_SVC  = 3'd1;
  localparam logic [2:0] OFS_LO   = 3'd2;
  localparam logic [2:0] OFS_HI   = 3'd3;
  localparam logic [2:0] OFS_DIV  = 3'd5;
  localparam int CB_EN   = 0;
  localparam int CB_POL  = 1;
  localparam int CB_INEN = 2;
  localparam int CB_IRQ  = 3;
  localparam logic [7:0] KEY_FIRST  = 8'hB4;
  localparam logic [7:0] KEY_SECOND = 8'h2C;
endpackage

// File: rtl/kww_regfile.sv
module kww_regfile
  import kww_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_vld,
  input  logic             bus_wr,
  input  logic [2:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic             bus_err,
  output logic             en,
  output logic             pol,
  output logic             inen,
  output logic             inten,
  output logic [CNT_W-1:0] cmp_lo,
  output logic [CNT_W-1:0] cmp_hi,
  output logic [DIV_W-1:0] div,
  output logic             start,
  output logic             svc_wr,
  output logic [7:0]       svc_data
);
  logic ctrl_lk, lo_lk, hi_lk, div_lk;
  logic wr_acc, rd_acc;
  logic [7:0] rd_mux;

  assign wr_acc   = bus_vld && bus_wr;
  assign rd_acc   = bus_vld && !bus_wr;
  assign svc_wr   = wr_acc && (bus_addr == OFS_SVC);
  assign svc_data = bus_wdata;

  always_comb begin
    case (bus_addr)
      OFS_CTRL: rd_mux = {4'b0, inten, inen, pol, en};
      OFS_LO:   rd_mux = 8'(cmp_lo);
      OFS_HI:   rd_mux = 8'(cmp_hi);
      OFS_DIV:  rd_mux = 8'(div);
      default:  rd_mux = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en <= 1'b0; pol <= 1'b0; inen <= 1'b0; inten <= 1'b0;
      cmp_lo <= '0; cmp_hi <= '1; div <= '0;
      ctrl_lk <= 1'b0; lo_lk <= 1'b0; hi_lk <= 1'b0; div_lk <= 1'b0;
      bus_rdata <= 8'h00; bus_err <= 1'b0; start <= 1'b0;
    end else begin
      bus_err   <= 1'b0;
      start     <= 1'b0;
      bus_rdata <= rd_acc ? rd_mux : 8'h00;
      if (wr_acc) begin
        case (bus_addr)
          OFS_CTRL: begin
            inten <= bus_wdata[CB_IRQ];
            if (!ctrl_lk) begin
              en      <= bus_wdata[CB_EN];
              pol     <= bus_wdata[CB_POL];
              inen    <= bus_wdata[CB_INEN];
              start   <= bus_wdata[CB_EN];
              ctrl_lk <= 1'b1;
            end else if (bus_wdata[2:0] != {inen, pol, en}) begin
              bus_err <= 1'b1;
            end
          end
          OFS_LO: begin
            if (lo_lk) bus_err <= 1'b1;
            else begin cmp_lo <= bus_wdata[CNT_W-1:0]; lo_lk <= 1'b1; end
          end
          OFS_HI: begin
            if (hi_lk) bus_err <= 1'b1;
            else begin cmp_hi <= bus_wdata[CNT_W-1:0]; hi_lk <= 1'b1; end
          end
          OFS_DIV: begin
            if (div_lk) bus_err <= 1'b1;
            else begin div <= bus_wdata[DIV_W-1:0]; div_lk <= 1'b1; end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: a locked compare-low write is refused and the value holds
  a_r2_lo_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && bus_addr == OFS_LO && lo_lk) |=> ($stable(cmp_lo) && bus_err));
  // R2: a locked prescaler write is refused and the value holds
  a_r2_div_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_acc && bus_addr == OFS_DIV && div_lk) |=> ($stable(div) && bus_err));
  // R3: an enabled monitor cannot be switched off
  a_r3_en_sticky: assert property (@(posedge clk) disable iff (rst)
    !$fell(en));
endmodule

// File: rtl/kww_timebase.sv
module kww_timebase #(
  parameter int CNT_W = 8,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             start,
  input  logic             clear,
  input  logic             slow_in,
  input  logic [DIV_W-1:0] div,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  logic s1, s2, s3, tick;
  logic [DIV_W-1:0] phase;

  assign tick = s2 && !s3;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= 1'b0; s2 <= 1'b0; s3 <= 1'b0;
      phase <= '0; cnt <= '0;
    end else begin
      s1 <= slow_in; s2 <= s1; s3 <= s2;
      if (start || clear) begin
        cnt   <= '0;
        phase <= '0;
      end else if (run && tick) begin
        if (phase == div) begin
          phase <= '0;
          if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end

  // R4: the counter holds or steps by one unless cleared
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (!start && !clear) |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));
  // R4: saturation at all-ones
  a_r4_saturate: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !start && !clear) |=> cnt == CNT_MAX);
endmodule

// File: rtl/kww_keycheck.sv
module kww_keycheck
  import kww_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int KEY_WIN = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             svc_wr,
  input  logic [7:0]       svc_data,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp_lo,
  input  logic [CNT_W-1:0] cmp_hi,
  output logic             refresh,
  output logic             bad
);
  localparam int TW = (KEY_WIN > 1) ? $clog2(KEY_WIN) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(KEY_WIN - 1);

  logic armed;
  logic [TW-1:0] timer;

  always_comb begin
    refresh = 1'b0;
    bad     = 1'b0;
    if (run) begin
      if (svc_wr) begin
        if (!armed) bad = (svc_data != KEY_FIRST);
        else if (svc_data != KEY_SECOND) bad = 1'b1;
        else if (cnt < cmp_lo) bad = 1'b1;
        else if (cnt <= cmp_hi) refresh = 1'b1;
      end else if (armed && timer == T_LAST) begin
        bad = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed <= 1'b0;
      timer <= '0;
    end else if (!run) begin
      armed <= 1'b0;
      timer <= '0;
    end else if (svc_wr) begin
      armed <= !armed && (svc_data == KEY_FIRST);
      timer <= '0;
    end else if (armed) begin
      if (timer == T_LAST) armed <= 1'b0;
      else timer <= timer + 1'b1;
    end
  end

  // R6: a refresh only completes a sequence that was armed by the first key
  a_r6_needs_first: assert property (@(posedge clk) disable iff (rst)
    refresh |-> armed);
  // R8: an armed sequence never outlives the key window
  a_r8_window: assert property (@(posedge clk) disable iff (rst)
    (armed && timer == T_LAST && !svc_wr) |=> !armed);
endmodule

// File: rtl/keyed_window_watchdog.sv
module keyed_window_watchdog
  import kww_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int DIV_W   = 8,
  parameter int KEY_WIN = 256
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_vld,
  input  logic       bus_wr,
  input  logic [2:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       bus_err,
  input  logic       slow_clk_in,
  input  logic       mon_in,
  output logic       alarm_out,
  output logic       irq_out
);
  logic en, pol, inen, inten, start, svc_wr;
  logic [7:0] svc_data;
  logic [CNT_W-1:0] cmp_lo, cmp_hi, cnt;
  logic [DIV_W-1:0] div;
  logic refresh, bad, m1, m2, mon_hit, expire, set_alarm, alarm_nx;

  kww_regfile #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .en(en), .pol(pol), .inen(inen), .inten(inten),
    .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .div(div), .start(start),
    .svc_wr(svc_wr), .svc_data(svc_data));

  kww_timebase #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_time (
    .clk(clk), .rst(rst), .run(en), .start(start), .clear(refresh),
    .slow_in(slow_clk_in), .div(div), .cnt(cnt));

  kww_keycheck #(.CNT_W(CNT_W), .KEY_WIN(KEY_WIN)) u_key (
    .clk(clk), .rst(rst), .run(en), .svc_wr(svc_wr), .svc_data(svc_data),
    .cnt(cnt), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .refresh(refresh), .bad(bad));

  assign mon_hit   = en && inen && (m2 == pol);
  assign expire    = en && (cnt > cmp_hi);
  assign set_alarm = bad || expire || mon_hit;

  always_comb begin
    if (set_alarm) alarm_nx = 1'b1;
    else if (refresh || start) alarm_nx = 1'b0;
    else alarm_nx = alarm_out;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m1 <= 1'b0; m2 <= 1'b0;
      alarm_out <= 1'b0; irq_out <= 1'b0;
    end else begin
      m1 <= mon_in; m2 <= m1;
      alarm_out <= alarm_nx;
      irq_out   <= inten && alarm_nx;
    end
  end

  // R5: exceeding the upper compare raises the alarm on the next edge
  a_r5_expire: assert property (@(posedge clk) disable iff (rst)
    (en && cnt > cmp_hi) |=> alarm_out);
  // R6: a clean refresh drops the alarm
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (refresh && !expire && !mon_hit) |=> !alarm_out);
  // R11: no interrupt without an alarm
  a_r11_irq_alarm: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> alarm_out);
  // R3: a block that is not enabled never alarms
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !en |=> !alarm_out);
endmodule

// File: tb/keyed_window_watchdog_tb.sv
module keyed_window_watchdog_tb;
  localparam int KW = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic bus_vld = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic bus_err, slow_clk_in = 1'b0, mon_in = 1'b1, alarm_out, irq_out;
  int n_chk = 0, n_bad = 0;

  keyed_window_watchdog #(.CNT_W(8), .DIV_W(8), .KEY_WIN(KW)) u_dut (
    .clk(clk), .rst(rst), .bus_vld(bus_vld), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .slow_clk_in(slow_clk_in), .mon_in(mon_in),
    .alarm_out(alarm_out), .irq_out(irq_out));

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; slow_clk_in = 1'b0; mon_in = 1'b1; bus_vld = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, output logic e);
    @(negedge clk);
    bus_vld = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_vld = 1'b0; e = bus_err;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_vld = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_vld = 1'b0; d = bus_rdata;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      slow_clk_in = 1'b1; repeat (4) @(negedge clk);
      slow_clk_in = 1'b0; repeat (4) @(negedge clk);
    end
  endtask

  task automatic key(input int gap);
    logic e;
    wr(3'd1, 8'hB4, e);
    repeat (gap) @(negedge clk);
    wr(3'd1, 8'h2C, e);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic e;
    logic [7:0] d;
    // R1 / R12 reset values and read map
    do_reset();
    chk("R1 alarm", alarm_out, 0);
    chk("R1 irq", irq_out, 0);
    rd(3'd0, d); chk("R1 ctrl", d, 0);
    rd(3'd2, d); chk("R1 lo", d, 0);
    rd(3'd3, d); chk("R1 hi", d, 255);
    rd(3'd5, d); chk("R1 div", d, 0);
    rd(3'd1, d); chk("R12 service reads zero", d, 0);
    rd(3'd4, d); chk("R12 reserved reads zero", d, 0);
    // R2 write-once
    wr(3'd2, 8'd3, e);  chk("R2 first lo write", e, 0);
    wr(3'd2, 8'd7, e);  chk("R2 second lo write err", e, 1);
    rd(3'd2, d);        chk("R2 lo kept", d, 3);
    wr(3'd3, 8'd9, e);  chk("R2 first hi write", e, 0);
    wr(3'd3, 8'd20, e); chk("R2 second hi write err", e, 1);
    rd(3'd3, d);        chk("R2 hi kept", d, 9);
    wr(3'd5, 8'd1, e);  chk("R2 first div write", e, 0);
    wr(3'd5, 8'd2, e);  chk("R2 second div write err", e, 1);
    rd(3'd5, d);        chk("R2 div kept", d, 1);
    wr(3'd0, 8'h01, e); chk("R2 first ctrl write", e, 0);
    wr(3'd0, 8'h03, e); chk("R2 ctrl change err", e, 1);
    wr(3'd0, 8'h00, e); chk("R3 disable attempt err", e, 1);
    rd(3'd0, d);        chk("R3 still enabled", d, 1);
    wr(3'd4, 8'hFF, e); chk("R2 reserved write no err", e, 0);
    wr(3'd1, 8'hB4, e); chk("R2 service write no err", e, 0);
    rd(3'd1, d);        chk("R12 service still zero", d, 0);

    // R3 first control write leaves it disabled
    do_reset();
    wr(3'd3, 8'd0, e);
    wr(3'd0, 8'h00, e);
    wr(3'd0, 8'h01, e); chk("R3 late enable refused", e, 1);
    pulses(5);
    wr(3'd1, 8'h55, e);
    repeat (2) @(negedge clk);
    chk("R3 disabled never alarms", alarm_out, 0);

    // R4 / R5 sweep of prescaler and upper compare
    for (int dv = 0; dv < 4; dv++) begin
      for (int h = 0; h < 6; h++) begin
        do_reset();
        wr(3'd3, 8'(h), e);
        wr(3'd5, 8'(dv), e);
        wr(3'd0, 8'h01, e);
        pulses((h + 1) * (dv + 1) - 1);
        chk("R4 no expiry one edge early", alarm_out, 0);
        pulses(1);
        chk("R5 expiry at count above upper compare", alarm_out, 1);
      end
    end

    // R4 / R5 saturation with all-ones upper compare
    do_reset();
    wr(3'd0, 8'h01, e);
    pulses(300);
    chk("R5 all-ones never expires", alarm_out, 0);

    // R6..R9 key sequence, lower 3 upper 10, no division
    do_reset();
    wr(3'd2, 8'd3, e);
    wr(3'd3, 8'd10, e);
    wr(3'd0, 8'h01, e);
    pulses(5); key(0);
    chk("R6 refresh in window", alarm_out, 0);
    pulses(10);
    chk("R6 counter was cleared", alarm_out, 0);
    key(KW - 2);
    chk("R8 last in-time cycle accepted", alarm_out, 0);
    pulses(1); key(0);
    chk("R9 refresh below lower compare", alarm_out, 1);
    pulses(3); key(0);
    chk("R6 refresh clears alarm", alarm_out, 0);
    pulses(3); key(0);
    chk("R6 lower bound inclusive", alarm_out, 0);
    pulses(4); wr(3'd1, 8'h55, e);
    chk("R7 wrong first byte", alarm_out, 1);
    key(0);
    chk("R6 recovery after wrong byte", alarm_out, 0);
    pulses(4); wr(3'd1, 8'hB4, e); wr(3'd1, 8'h11, e);
    chk("R7 wrong second byte", alarm_out, 1);
    key(0);
    chk("R6 recovery after wrong second byte", alarm_out, 0);
    pulses(4); key(KW - 1);
    chk("R8 late second byte", alarm_out, 1);
    key(0);
    chk("R6 recovery after late key", alarm_out, 0);
    pulses(11);
    chk("R5 expiry above upper compare", alarm_out, 1);
    key(0);
    chk("R6 no refresh after expiry", alarm_out, 1);

    // R10 external input polarity and gating
    do_reset();
    wr(3'd0, 8'h05, e);
    repeat (6) @(negedge clk);
    chk("R10 active-low idle high", alarm_out, 0);
    mon_in = 1'b0; repeat (6) @(negedge clk);
    chk("R10 active-low asserted", alarm_out, 1);
    do_reset();
    mon_in = 1'b0; repeat (4) @(negedge clk);
    wr(3'd0, 8'h07, e);
    repeat (6) @(negedge clk);
    chk("R10 active-high idle low", alarm_out, 0);
    mon_in = 1'b1; repeat (6) @(negedge clk);
    chk("R10 active-high asserted", alarm_out, 1);
    do_reset();
    wr(3'd0, 8'h01, e);
    mon_in = 1'b0; repeat (6) @(negedge clk);
    mon_in = 1'b1; repeat (6) @(negedge clk);
    chk("R10 input ignored when not enabled", alarm_out, 0);

    // R11 interrupt
    do_reset();
    wr(3'd3, 8'd0, e);
    wr(3'd0, 8'h09, e);
    pulses(1);
    chk("R11 irq with alarm", irq_out, 1);
    wr(3'd0, 8'h01, e);
    chk("R11 clearing irq enable no err", e, 0);
    repeat (2) @(negedge clk);
    chk("R11 irq removed", irq_out, 0);
    chk("R11 alarm kept", alarm_out, 1);
    rd(3'd0, d); chk("R11 ctrl readback", d, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule